// File: doc/BRIEF.md
# Link Power Status Monitor

This block sits on the PHY side of a PHY-to-link connection. It watches the power status level that the link-layer controller drives and decides whether the interface is active, held in reset, or disabled. The controller may hold the level steadily high or toggle it as a pulse train. A short low phase of a pulse train must not disturb the interface. Only an unbroken low stretch that lasts past a first threshold resets the interface, and a stretch that lasts past a second, much longer threshold disables it.

The raw status level passes through a two-flop synchronizer. A counter in the PHY clock domain then measures how long the synchronized level has stayed low, and any sampled high level clears it. A three-state controller uses the count to pick the interface state. While the state is not active, the block forces the outgoing control (2 bits) and data (8 bits) lines to zero and masks the incoming link request. The system clock enable is low only while the interface is disabled. It comes back within two clock edges once the level returns high.

The thresholds are cycle counts. The defaults assume a 49.152 MHz PHY clock and, counting the synchronizer delay, place the reset decision at about 2.665 µs and the disable decision at about 26.10 µs of continuous deassertion.

Top module: `link_power_monitor`

## Requirements
- R1: After the asynchronous reset, the state output reads disabled (2), sysclk_en is 0, drive_en is 0 and req_mask is 1.
- R2: The state output encodes active as 0, reset as 1 and disabled as 2. From the disabled or reset state, a high level on pwr_status_i makes the state active on the third rising clock edge after the input rises, and not earlier.
- R3: A low phase of pwr_status_i that lasts at most RESET_CYCLES clock periods, repeated as a pulse train with high phases of one period or more, never moves the state away from active.
- R4: If pwr_status_i stays low continuously from the active state, the state becomes reset on the (RESET_CYCLES+3)-th rising edge after the fall and is still active one edge before that.
- R5: If pwr_status_i stays low continuously, the state becomes disabled on the (DISABLE_CYCLES+3)-th rising edge after the fall. The state never goes from active to disabled in one step.
- R6: If pwr_status_i returns high while in the reset state, before the disable point, the block goes back to active and never passes through disabled.
- R7: In the active state, ctl_o and dat_o equal ctl_i and dat_i. In any other state, both are 0.
- R8: In the active state, req_o equals req_i and req_mask is 0. In any other state, req_o is 0 and req_mask is 1, whatever req_i does.
- R9: sysclk_en is 0 only in the disabled state. After pwr_status_i rises while disabled, sysclk_en goes high on the second rising edge and not on the first.
- R10: Once it is disabled, the block stays disabled for as long as pwr_status_i stays low. The low-time counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_status_i | input | 1 | Raw power status level from the link controller |
| ctl_i | input | 2 | Control lines from the PHY core toward the link |
| dat_i | input | 8 | Data lines from the PHY core toward the link |
| req_i | input | 1 | Link request line from the link controller |
| if_state | output | 2 | Interface state: 0 active, 1 reset, 2 disabled |
| drive_en | output | 1 | High while the outgoing lines are allowed to carry data |
| req_mask | output | 1 | High while link requests are ignored |
| sysclk_en | output | 1 | System clock enable toward the link |
| ctl_o | output | 2 | Gated control lines |
| dat_o | output | 8 | Gated data lines |
| req_o | output | 1 | Masked link request |

## Verification
On every cycle, the embedded properties check several facts. The gated lines and the request are zero whenever the state is not active. A synchronized high level clears the counter and selects active on the next edge. Active is never followed directly by disabled, and the reset state is entered only from active. The counter never exceeds its ceiling, and a rising synchronized level out of the disabled state raises the clock enable at once. The exact edge on which reset and disable are declared, the tolerance to pulse trains whose low phase sits just at the threshold, and the return from reset without a disable can be shown only by the bench's directed scenarios, which count edges from the raw input.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    IF_ACTIVE   = 2'd0,
    IF_RESET    = 2'd1,
    IF_DISABLED = 2'd2
  } if_state_t;

  // Width needed to hold the values 0..limit.
  function automatic int unsigned count_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
  parameter int unsigned RESET_CYCLES   = 129,
  parameter int unsigned DISABLE_CYCLES = 1281,
  localparam int unsigned CW = lpm_pkg::count_width(DISABLE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_i,
  output logic [CW-1:0] low_count,
  output logic          reset_hit,
  output logic          disable_hit
);
  localparam logic [CW-1:0] RST_LIM = CW'(RESET_CYCLES);
  localparam logic [CW-1:0] DIS_LIM = CW'(DISABLE_CYCLES);

  // Saturating step of the low-time counter.
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cur,
                                                input logic lvl);
    if (lvl)                 return '0;
    else if (cur >= DIS_LIM) return DIS_LIM;
    else                     return cur + CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_count <= '0;
    else        low_count <= step_count(low_count, level_i);

  assign reset_hit   = (low_count >= RST_LIM);
  assign disable_hit = (low_count >= DIS_LIM);

  // R10
  count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_count <= DIS_LIM);
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && disable_hit) |=> disable_hit);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  input  logic      reset_hit,
  input  logic      disable_hit,
  output if_state_t state
);
  if_state_t state_nx;

  always_comb begin
    state_nx = state;
    if (level_i) state_nx = IF_ACTIVE;
    else begin
      case (state)
        IF_ACTIVE:   if (reset_hit)   state_nx = IF_RESET;
        IF_RESET:    if (disable_hit) state_nx = IF_DISABLED;
        default:     state_nx = IF_DISABLED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= IF_DISABLED;
    else        state <= state_nx;

  // R2
  wake_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_i |=> state == IF_ACTIVE);
  // R5
  no_direct_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == IF_ACTIVE |=> state != IF_DISABLED);
  // R6
  reset_only_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IF_RESET && $past(state) != IF_RESET) |-> $past(state) == IF_ACTIVE);
  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
  import lpm_pkg::*;
#(
  parameter int unsigned RESET_CYCLES   = 129,
  parameter int unsigned DISABLE_CYCLES = 1281,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned CTL_W          = 2,
  parameter int unsigned DAT_W          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_status_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic             req_i,
  output logic [1:0]       if_state,
  output logic             drive_en,
  output logic             req_mask,
  output logic             sysclk_en,
  output logic [CTL_W-1:0] ctl_o,
  output logic [DAT_W-1:0] dat_o,
  output logic             req_o
);
  localparam int unsigned CW = count_width(DISABLE_CYCLES);

  // Named internal events used by the assertions.
  logic          level_s;
  logic [CW-1:0] low_count;
  logic          reset_hit;
  logic          disable_hit;
  if_state_t     state;

  lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pwr_status_i), .q_o(level_s)
  );

  lpm_low_timer #(
    .RESET_CYCLES(RESET_CYCLES), .DISABLE_CYCLES(DISABLE_CYCLES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .level_i(level_s), .low_count(low_count),
    .reset_hit(reset_hit), .disable_hit(disable_hit)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .level_i(level_s), .reset_hit(reset_hit),
    .disable_hit(disable_hit), .state(state)
  );

  assign if_state  = state;
  assign drive_en  = (state == IF_ACTIVE);
  assign req_mask  = !drive_en;
  assign sysclk_en = (state != IF_DISABLED) || level_s;
  assign ctl_o     = drive_en ? ctl_i : '0;
  assign dat_o     = drive_en ? dat_i : '0;
  assign req_o     = req_i && !req_mask;

  initial begin
    if (RESET_CYCLES == 0 || RESET_CYCLES >= DISABLE_CYCLES)
      $error("threshold parameters out of order");
  end

  // R7
  lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != IF_ACTIVE |-> (ctl_o == '0 && dat_o == '0));
  // R8
  req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != IF_ACTIVE |-> (!req_o && req_mask));
  // R3
  high_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_s |=> low_count == '0);
  // R9
  clock_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(level_s) && state == IF_DISABLED) |-> sysclk_en);
endmodule

// File: tb/sim_link_power_monitor.sv
module sim_link_power_monitor;
  localparam int unsigned RST_N = 129;
  localparam int unsigned DIS_N = 1281;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 1'b0;
  logic [1:0] ctl_i = '0;
  logic [7:0] dat_i = '0;
  logic       req_i = 1'b0;
  logic [1:0] if_state;
  logic       drive_en, req_mask, sysclk_en, req_o;
  logic [1:0] ctl_o;
  logic [7:0] dat_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  link_power_monitor #(.RESET_CYCLES(RST_N), .DISABLE_CYCLES(DIS_N)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_status_i(pwr), .ctl_i(ctl_i), .dat_i(dat_i),
    .req_i(req_i), .if_state(if_state), .drive_en(drive_en), .req_mask(req_mask),
    .sysclk_en(sysclk_en), .ctl_o(ctl_o), .dat_o(dat_o), .req_o(req_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Advance n rising edges, staying in the falling-edge phase.
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 state after reset", if_state, 2);
    chk("R1 sysclk_en after reset", sysclk_en, 0);
    chk("R1 drive_en after reset", drive_en, 0);
    chk("R1 req_mask after reset", req_mask, 1);
  endtask

  task automatic t_wake();
    pwr = 1'b1;
    step(1);
    chk("R9 sysclk_en one edge after rise", sysclk_en, 0);
    step(1);
    chk("R9 sysclk_en two edges after rise", sysclk_en, 1);
    chk("R2 still disabled at edge two", if_state, 2);
    step(1);
    chk("R2 active at edge three", if_state, 0);
  endtask

  task automatic t_passthrough();
    ctl_i = 2'b10; dat_i = 8'hA5; req_i = 1'b1;
    #1;
    chk("R7 ctl passes in active", ctl_o, 2'b10);
    chk("R7 dat passes in active", dat_o, 8'hA5);
    chk("R8 req passes in active", req_o, 1);
    chk("R8 mask low in active", req_mask, 0);
  endtask

  task automatic t_pulse();
    logic left = 1'b0;
    for (int p = 0; p < 4; p++) begin
      pwr = 1'b0;
      for (int k = 0; k < RST_N; k++) begin
        step(1);
        if (if_state != 0) left = 1'b1;
      end
      pwr = 1'b1;
      for (int k = 0; k < (p == 0 ? 1 : 3 + p * 20); k++) begin
        step(1);
        if (if_state != 0) left = 1'b1;
      end
    end
    step(4);
    chk("R3 pulse train keeps active", {31'd0, left}, 0);
    chk("R3 state after pulse train", if_state, 0);
  endtask

  task automatic t_reset_entry();
    pwr = 1'b0;
    step(RST_N + 2);
    chk("R4 active one edge before threshold", if_state, 0);
    step(1);
    chk("R4 reset at threshold edge", if_state, 1);
    chk("R7 ctl zero in reset", ctl_o, 0);
    chk("R7 dat zero in reset", dat_o, 0);
    req_i = 1'b0; #1; req_i = 1'b1; #1;
    chk("R8 req ignored in reset", req_o, 0);
    chk("R8 mask high in reset", req_mask, 1);
    chk("R9 sysclk_en on in reset", sysclk_en, 1);
  endtask

  task automatic t_recover();
    logic hit_dis = 1'b0;
    for (int k = 0; k < 500; k++) begin
      step(1);
      if (if_state == 2) hit_dis = 1'b1;
    end
    pwr = 1'b1;
    step(2);
    chk("R2 reset held at edge two", if_state, 1);
    step(1);
    chk("R6 back to active", if_state, 0);
    chk("R6 no disable on the way", {31'd0, hit_dis}, 0);
    chk("R7 dat passes again", dat_o, 8'hA5);
  endtask

  task automatic t_disable();
    pwr = 1'b0;
    step(RST_N + 3);
    chk("R5 reset reached first", if_state, 1);
    step(DIS_N - RST_N - 1);
    chk("R5 still reset one edge before", if_state, 1);
    step(1);
    chk("R5 disabled at threshold edge", if_state, 2);
    chk("R9 sysclk_en off when disabled", sysclk_en, 0);
    chk("R8 req ignored when disabled", req_o, 0);
    step(3000);
    chk("R10 long low stays disabled", if_state, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(2);
    t_reset_state();
    t_wake();
    t_passthrough();
    t_pulse();
    t_reset_entry();
    t_recover();
    t_disable();
    t_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule